// File: doc/BRIEF.md
# Single-Bit Memory Operation Unit

This unit carries out the single-bit memory instructions of an 8-bit processor core. One opcode byte selects the operation class, a bit index and a polarity. The unit reads one byte at an 8-bit direct address through a synchronous memory port. It then does one of two things. For a modify form, it writes the byte back with one bit forced to 1 or to 0. For a test form, it decides whether to take a relative jump and computes the next program counter from a signed 8-bit displacement.

The sequencer of the core supplies the opcode, the address byte, the displacement byte and the program counter of the byte that follows the three-byte instruction, and pulses `start_i`. The unit answers with `done_o`. The branch decision, the tested bit (as a carry output) and the next program counter stay on the outputs until a later test or modify operation replaces them. Instruction fetch is handled elsewhere.

Opcode layout: bits [7:4] hold the class, bits [3:1] hold the bit index, and bit [0] holds the polarity. Class 0000 is test-and-jump and class 0001 is modify. The memory returns read data on `mem_rdata_i` in the cycle after the one in which `mem_rd_o` is high.

Top module: `bitop_unit`

## Requirements
- R1: Opcode 0000_bbb_0 (test, polarity 0) takes the jump exactly when bit bbb of the addressed byte is 1.
- R2: Opcode 0000_bbb_1 (test, polarity 1) takes the jump exactly when bit bbb of the addressed byte is 0.
- R3: After a taken test, `pc_next_o` equals `pc_i` plus the sign-extended `offset_i`, modulo 2^16. After a not-taken test or any modify form, `pc_next_o` equals `pc_i` and `taken_o` is 0.
- R4: A test form copies the tested bit to `carry_o` and never asserts `mem_wr_o`. A modify form leaves `carry_o` unchanged.
- R5: Opcode 0001_bbb_0 writes the read byte back to the same address with bit bbb set. Opcode 0001_bbb_1 writes it back with bit bbb cleared. The other seven bits are unchanged in both cases.
- R6: For every accepted operation, `mem_rd_o` is high for exactly one cycle, namely the cycle after the accepting edge. A modify form raises `mem_wr_o` for exactly one cycle, two cycles after the read cycle. Read and write are never high together.
- R7: `done_o` is high for exactly one cycle. For a test form this is the 3rd cycle after the accepting edge; for a modify form it is the 4th.
- R8: A `start_i` that arrives while `busy_o` is high, including the cycle in which `done_o` is high, is ignored. It causes no memory access and no extra `done_o`.
- R9: A `start_i` whose opcode class is neither 0000 nor 0001 is ignored. The unit stays idle, makes no memory access and gives no `done_o`.
- R10: After reset, `busy_o`, `done_o`, `mem_rd_o`, `mem_wr_o`, `taken_o` and `carry_o` are 0, and `pc_next_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe, sampled only while idle |
| opcode_i | input | 8 | Class, bit index and polarity |
| addr_i | input | 8 | Direct memory address of the operand byte |
| offset_i | input | 8 | Signed jump displacement (test forms) |
| pc_i | input | 16 | Address of the byte after the instruction |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 8 | Memory address |
| mem_wdata_o | output | 8 | Modified byte to write |
| mem_rdata_i | input | 8 | Read data, valid the cycle after `mem_rd_o` |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| taken_o | output | 1 | Jump decision of the last test |
| carry_o | output | 1 | Tested bit of the last test |
| pc_next_o | output | 16 | Next program counter |

## Verification
Two events can fall in the same cycle: the completion pulse and a fresh request strobe. A request can also arrive during the evaluation cycle of a running operation. The bench provokes both by raising `start_i` with a valid opcode in the evaluation cycle and again in the cycle in which `done_o` is high. It then judges that the read, write and done counts rose by exactly one operation's worth and that `busy_o` is low in the following cycle. Separately, the modify path and the test path are chained on the same byte, so that a later test sees the bit written by an earlier modify.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_READ  = 3'd1,
      ST_EVAL  = 3'd2,
      ST_WRITE = 3'd3,
      ST_FIN   = 3'd4
   } bitop_state_e;

endpackage

// File: rtl/bitop_decode.sv
module bitop_decode #(
   parameter int OPC_W = 8,
   parameter int IDX_W = 3
) (
   input  logic [OPC_W-1:0] opcode,
   output logic             valid,
   output logic             is_test,
   output logic             polarity,
   output logic [IDX_W-1:0] idx
);
   localparam int CLS_W = OPC_W - IDX_W - 1;

   logic [CLS_W-1:0] cls;

   assign cls      = opcode[OPC_W-1 -: CLS_W];
   assign valid    = (cls[CLS_W-1:1] == '0);
   assign is_test  = ~cls[0];
   assign polarity = opcode[0];
   assign idx      = opcode[IDX_W:1];
endmodule

// File: rtl/bitop_modify.sv
module bitop_modify #(
   parameter int DATA_W = 8,
   parameter int IDX_W  = 3
) (
   input  logic [DATA_W-1:0] din,
   input  logic [IDX_W-1:0]  idx,
   input  logic              polarity,
   output logic [DATA_W-1:0] dout,
   output logic              sel_bit
);
   assign sel_bit = din[idx];

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      assign dout[i] = (idx == IDX_W'(i)) ? ~polarity : din[i];
   end
endmodule

// File: rtl/bitop_target.sv
module bitop_target #(
   parameter int PC_W  = 16,
   parameter int OFF_W = 8
) (
   input  logic [PC_W-1:0]  pc,
   input  logic [OFF_W-1:0] off,
   output logic [PC_W-1:0]  target
);
   if (PC_W > OFF_W) begin : g_sext
      assign target = pc + {{(PC_W-OFF_W){off[OFF_W-1]}}, off};
   end else begin : g_trunc
      assign target = pc + off[PC_W-1:0];
   end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
   import bitop_pkg::*;
#(
   parameter int OPC_W  = 8,
   parameter int DATA_W = 8,
   parameter int ADDR_W = 8,
   parameter int PC_W   = 16,
   parameter int OFF_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [OPC_W-1:0]  opcode_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [OFF_W-1:0]  offset_i,
   input  logic [PC_W-1:0]   pc_i,
   output logic              mem_rd_o,
   output logic              mem_wr_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              taken_o,
   output logic              carry_o,
   output logic [PC_W-1:0]   pc_next_o
);
   localparam int IDX_W = $clog2(DATA_W);

   initial begin
      if (DATA_W != (1 << IDX_W))
         $fatal(1, "bitop_unit: DATA_W must be a power of two");
      if (OPC_W < IDX_W + 3)
         $fatal(1, "bitop_unit: OPC_W too narrow for class, index and polarity");
      if (OFF_W < 2)
         $fatal(1, "bitop_unit: OFF_W too narrow");
   end

   bitop_state_e state_q, state_d;

   logic              dec_valid, dec_test, dec_pol;
   logic [IDX_W-1:0]  dec_idx;
   logic              op_test_q, op_pol_q;
   logic [IDX_W-1:0]  op_idx_q;
   logic [ADDR_W-1:0] op_addr_q;
   logic [OFF_W-1:0]  op_off_q;
   logic [PC_W-1:0]   op_pc_q;
   logic [DATA_W-1:0] wdata_q, mod_byte;
   logic              sel_bit, hit;
   logic              taken_q, carry_q;
   logic [PC_W-1:0]   pc_next_q, jump_pc;
   logic              accept;

   bitop_decode #(.OPC_W(OPC_W), .IDX_W(IDX_W)) u_dec (
      .opcode   (opcode_i),
      .valid    (dec_valid),
      .is_test  (dec_test),
      .polarity (dec_pol),
      .idx      (dec_idx)
   );

   bitop_modify #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_mod (
      .din      (mem_rdata_i),
      .idx      (op_idx_q),
      .polarity (op_pol_q),
      .dout     (mod_byte),
      .sel_bit  (sel_bit)
   );

   bitop_target #(.PC_W(PC_W), .OFF_W(OFF_W)) u_tgt (
      .pc     (op_pc_q),
      .off    (op_off_q),
      .target (jump_pc)
   );

   assign accept = (state_q == ST_IDLE) && start_i && dec_valid;
   assign hit    = sel_bit ^ op_pol_q;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:  if (accept) state_d = ST_READ;
         ST_READ:  state_d = ST_EVAL;
         ST_EVAL:  state_d = op_test_q ? ST_FIN : ST_WRITE;
         ST_WRITE: state_d = ST_FIN;
         ST_FIN:   state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         op_test_q <= 1'b0;
         op_pol_q  <= 1'b0;
         op_idx_q  <= '0;
         op_addr_q <= '0;
         op_off_q  <= '0;
         op_pc_q   <= '0;
         wdata_q   <= '0;
         taken_q   <= 1'b0;
         carry_q   <= 1'b0;
         pc_next_q <= '0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            op_test_q <= dec_test;
            op_pol_q  <= dec_pol;
            op_idx_q  <= dec_idx;
            op_addr_q <= addr_i;
            op_off_q  <= offset_i;
            op_pc_q   <= pc_i;
         end
         if (state_q == ST_EVAL) begin
            if (op_test_q) begin
               taken_q   <= hit;
               carry_q   <= sel_bit;
               pc_next_q <= hit ? jump_pc : op_pc_q;
            end else begin
               wdata_q   <= mod_byte;
               taken_q   <= 1'b0;
               pc_next_q <= op_pc_q;
            end
         end
      end
   end

   assign mem_rd_o    = (state_q == ST_READ);
   assign mem_wr_o    = (state_q == ST_WRITE);
   assign mem_addr_o  = op_addr_q;
   assign mem_wdata_o = wdata_q;
   assign busy_o      = (state_q != ST_IDLE);
   assign done_o      = (state_q == ST_FIN);
   assign taken_o     = taken_q;
   assign carry_o     = carry_q;
   assign pc_next_o   = pc_next_q;
endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              mem_rd_o,
   input logic              mem_wr_o,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic [DATA_W-1:0] mem_wdata_o,
   input logic [DATA_W-1:0] mem_rdata_i,
   input logic              busy_o,
   input logic              done_o
);
   // R6
   rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_o && mem_wr_o));

   // R6
   rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_o |=> !mem_rd_o);

   // R8
   rd_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_o |-> ($past(start_i) && !$past(busy_o)));

   // R6
   wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_o |-> $past(mem_rd_o, 2));

   // R5
   wr_same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_o |-> (mem_addr_o == $past(mem_addr_o, 2)));

   // R5
   wr_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_o |-> ($countones(mem_wdata_o ^ $past(mem_rdata_i)) <= 1));

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R7
   wr_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_o |=> done_o);
endmodule

bind bitop_unit bitop_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .mem_rd_o    (mem_rd_o),
   .mem_wr_o    (mem_wr_o),
   .mem_addr_o  (mem_addr_o),
   .mem_wdata_o (mem_wdata_o),
   .mem_rdata_i (mem_rdata_i),
   .busy_o      (busy_o),
   .done_o      (done_o)
);

// File: tb/bitop_unit_test.sv
`timescale 1ns/1ps
module bitop_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [7:0]  opcode_i = '0, addr_i = '0, offset_i = '0;
   logic [15:0] pc_i = '0;
   logic        mem_rd_o, mem_wr_o, busy_o, done_o, taken_o, carry_o;
   logic [7:0]  mem_addr_o, mem_wdata_o;
   logic [7:0]  mem_rdata_i = '0;
   logic [15:0] pc_next_o;

   typedef struct {
      logic        taken;
      logic        carry;
      logic [15:0] pc_next;
      logic        is_mod;
      logic [7:0]  addr;
      logic [7:0]  byte_v;
   } exp_t;

   exp_t        sb[$];
   logic [7:0]  mem    [256];
   logic [7:0]  shadow [256];
   int          checks = 0, fails = 0;
   int          cyc = 0, rd_cnt = 0, wr_cnt = 0, done_cnt = 0;
   int          rd_cyc = 0, wr_cyc = 0;
   logic        last_carry = 1'b0;
   bit          finished = 1'b0;

   always #2 clk = ~clk;

   bitop_unit uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .opcode_i(opcode_i),
      .addr_i(addr_i), .offset_i(offset_i), .pc_i(pc_i),
      .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .mem_addr_o(mem_addr_o),
      .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
      .busy_o(busy_o), .done_o(done_o), .taken_o(taken_o),
      .carry_o(carry_o), .pc_next_o(pc_next_o)
   );

   // synchronous memory model
   always @(posedge clk) begin
      cyc = cyc + 1;
      if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o];
      if (mem_wr_o) mem[mem_addr_o] <= mem_wdata_o;
   end

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, got, exp);
      end
   endtask

   // monitor: counts accesses, pops scoreboard on completion
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_rd_o) begin rd_cnt++; rd_cyc = cyc; end
         if (mem_wr_o) begin wr_cnt++; wr_cyc = cyc; end
         if (done_o) begin
            done_cnt++;
            if (sb.size() == 0) begin
               chk("R8 unexpected done", 32'd1, 32'd0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               chk(e.is_mod ? "R5 taken" : "R1/R2 taken", 32'(taken_o), 32'(e.taken));
               chk("R3 pc_next", 32'(pc_next_o), 32'(e.pc_next));
               chk("R4 carry", 32'(carry_o), 32'(e.carry));
               chk("R5 memory byte", 32'(mem[e.addr]), 32'(e.byte_v));
            end
         end
      end
   end

   task automatic run_op(input logic [7:0] opc, input logic [7:0] a,
                         input logic [7:0] off, input logic [15:0] pc,
                         input bit harass);
      exp_t e;
      logic b, is_test;
      int rd0, wr0, dn0, s, n;
      is_test = (opc[7:4] == 4'h0);
      b = shadow[a][opc[3:1]];
      e.is_mod = !is_test;
      e.addr = a;
      e.taken = is_test ? (b ^ opc[0]) : 1'b0;
      e.carry = is_test ? b : last_carry;
      last_carry = e.carry;
      e.pc_next = e.taken ? pc + {{8{off[7]}}, off} : pc;
      if (!is_test) shadow[a][opc[3:1]] = ~opc[0];
      e.byte_v = shadow[a];
      sb.push_back(e);
      rd0 = rd_cnt; wr0 = wr_cnt; dn0 = done_cnt;
      @(negedge clk);
      opcode_i = opc; addr_i = a; offset_i = off; pc_i = pc; start_i = 1'b1;
      s = cyc;
      @(negedge clk);
      start_i = 1'b0;
      n = 1;
      while (!done_o && n < 20) begin
         @(negedge clk);
         n++;
         start_i = harass && (n == 2);
      end
      // R7 latency
      chk("R7 done latency", 32'(n), is_test ? 32'd3 : 32'd4);
      if (harass) start_i = 1'b1;   // R8: start in the done cycle
      @(negedge clk);
      start_i = 1'b0;
      chk("R7 done one cycle", 32'(done_o), 32'd0);
      if (harass) chk("R8 idle after busy start", 32'(busy_o), 32'd0);
      repeat (3) @(negedge clk);
      chk("R6 one read", 32'(rd_cnt - rd0), 32'd1);
      chk("R6 read cycle", 32'(rd_cyc - s), 32'd1);
      chk("R8 one done", 32'(done_cnt - dn0), 32'd1);
      if (is_test) begin
         chk("R4 no write on test", 32'(wr_cnt - wr0), 32'd0);
      end else begin
         chk("R5 one write", 32'(wr_cnt - wr0), 32'd1);
         chk("R6 write cycle", 32'(wr_cyc - s), 32'd3);
      end
   endtask

   task automatic bad_op(input logic [7:0] opc);
      int rd0, dn0;
      rd0 = rd_cnt; dn0 = done_cnt;
      @(negedge clk);
      opcode_i = opc; addr_i = 8'h10; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk("R9 stays idle", 32'(busy_o), 32'd0);
      repeat (5) @(negedge clk);
      chk("R9 no read", 32'(rd_cnt - rd0), 32'd0);
      chk("R9 no done", 32'(done_cnt - dn0), 32'd0);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) begin
         mem[i] = 8'(i * 37 + 11);
         shadow[i] = mem[i];
      end
      mem[8'h10] = 8'hA5; shadow[8'h10] = 8'hA5;
      mem[8'hFF] = 8'h00; shadow[8'hFF] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk("R10 busy", 32'(busy_o), 32'd0);
      chk("R10 done", 32'(done_o), 32'd0);
      chk("R10 rd/wr", 32'({mem_rd_o, mem_wr_o}), 32'd0);
      chk("R10 taken/carry", 32'({taken_o, carry_o}), 32'd0);
      chk("R10 pc_next", 32'(pc_next_o), 32'd0);

      run_op(8'h00, 8'h10, 8'h05, 16'h0200, 1'b0); // R1 bit0=1 -> taken
      run_op(8'h02, 8'h10, 8'h05, 16'h0200, 1'b0); // R1 bit1=0 -> not taken
      run_op(8'h0D, 8'h10, 8'hF0, 16'h0300, 1'b0); // R2 bit6=0 -> taken, backward (R3)
      run_op(8'h0F, 8'h10, 8'hF0, 16'h0300, 1'b0); // R2 bit7=1 -> not taken
      run_op(8'h04, 8'h10, 8'h20, 16'hFFF0, 1'b0); // R3 wrap to 0x0010
      run_op(8'h0F, 8'hFF, 8'h80, 16'h0100, 1'b0); // R3 -128 -> 0x0080
      run_op(8'h1C, 8'h10, 8'h00, 16'h0400, 1'b0); // R5 set bit6: A5 -> E5
      run_op(8'h11, 8'h10, 8'h00, 16'h0400, 1'b0); // R5 clear bit0: E5 -> E4
      run_op(8'h1E, 8'h10, 8'h00, 16'h0400, 1'b0); // R5 set already-set bit7
      run_op(8'h0C, 8'h10, 8'h7F, 16'h1000, 1'b0); // R1 sees written bit6
      run_op(8'h01, 8'h10, 8'h7F, 16'h1000, 1'b1); // R8 harassed test
      run_op(8'h13, 8'h3C, 8'h00, 16'h2000, 1'b1); // R8 harassed modify
      bad_op(8'h20);                               // R9
      bad_op(8'h9A);                               // R9
      run_op(8'h1F, 8'hFF, 8'h00, 16'h0500, 1'b0); // R5 clear bit7 on zero byte
      chk("R8 scoreboard drained", 32'(sb.size()), 32'd0);
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end
endmodule